// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Default-Master Parking

This block sits in front of one slave port of a multi-layer bus interconnect. Up to sixteen masters raise request lines toward the slave. The arbiter chooses one of them and drives a one-hot grant vector, a binary grant index and a valid flag. The grant stays with the chosen master until that master signals the last beat of its burst or single transfer. Only at that boundary does the arbiter pick again.

Two settings come in on plain input ports, and both can change at run time. The first is the arbitration policy: rotating round-robin, or fixed priority with a programmable priority value for each master. The second is the default-master ("parking") mode. When no transfer is pending, the slave can stay connected to no master, to the master that finished last, or to a fixed master chosen by an ID input. A master that finds the slave already parked on it starts with no added cycle. Any other master is granted one cycle after its request is first seen.

Top module: `park_arb`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), and on the first cycle after it rises, `gnt` is all zeros, `gnt_vld` is 0 and `gnt_idx` is 0. The round-robin search position starts at master 0.
- R2: `gnt` has at most one bit set. `gnt_vld` is 1 exactly when a bit is set, and `gnt_idx` holds that bit's position (0 when `gnt_vld` is 0).
- R3: When the slave is idle and a request arrives from a master the slave is not parked on, the grant goes to a requesting master on the clock edge where the request is first sampled. The grant is therefore visible one cycle after the request.
- R4: When the slave is idle and parked on a master, a request from that master finds `gnt` already asserted in the same cycle, and `gnt` does not change on the following edge.
- R5: While a transfer is in progress, `gnt` does not change until `xfer_end[i]` is sampled high for the granted master i. Other masters' requests and other masters' `xfer_end` bits are ignored.
- R6: With `cfg_policy`=0 (round-robin), the search for the next winner starts at the master after the most recently granted one and wraps from N-1 to 0.
- R7: With `cfg_policy`=1 (fixed priority), the requester with the largest priority value wins. The value for master i is `cfg_prio[i*PRIO_W +: PRIO_W]`. Among equal values, the lowest index wins.
- R8: With `cfg_park_mode`=0 (no default master; code 3 behaves the same), `gnt` goes to all zeros on the cycle after a transfer ends if no other request is pending.
- R9: With `cfg_park_mode`=1 (last master), the slave stays connected to the master that completed the most recent transfer when no request is pending. Before any transfer has completed, it behaves as with code 0.
- R10: With `cfg_park_mode`=2 (fixed master), the slave parks on master `cfg_park_id` when no request is pending. An ID of N or more parks nowhere.
- R11: On the edge where a transfer ends, the completing master's own request is excluded from arbitration. If other requests are pending, the winner among them holds `gnt` on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_MST | Request line from each master, held high through its transfer |
| xfer_end | input | NUM_MST | Last-beat flag from each master; only the granted master's bit is used |
| cfg_policy | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_park_mode | input | 2 | 0 none, 1 last master, 2 fixed master, 3 none |
| cfg_park_id | input | IDX_W | Master used by the fixed parking mode |
| cfg_prio | input | NUM_MST*PRIO_W | Packed priority values, master i in field i |
| gnt | output | NUM_MST | One-hot grant |
| gnt_idx | output | IDX_W | Index of the granted master |
| gnt_vld | output | 1 | A master is granted or parked |

## Verification
Requests are applied in four patterns, and each separates a different mechanism.

- A single request toward an idle slave that is not parked on that master shows the one-cycle first-access latency. The same single request toward a slave parked on that master shows the zero-cycle path.
- Overlapping requests that arrive during a burst, together with stray end flags from masters that are not granted, show that the grant holds until the owner's own end flag.
- Three and four simultaneous requests are chained through back-to-back hand-overs. Under round-robin these expose the pointer rotation, the wrap-around and the exclusion of the finishing master. Under fixed priority with a tie they expose the value ordering and the lowest-index rule.
- Transfers ending with nothing pending are repeated under each parking code, so an empty grant, parking on the last master and parking on the fixed ID can be told apart.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        POL_RR   = 1'b0,
        POL_PRIO = 1'b1
    } pol_e;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_MST = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_MST-1:0] req,
    input  logic [IDX_W-1:0]   start,
    output logic               found,
    output logic [IDX_W-1:0]   sel
);

    function automatic int wrap(input int a);
        return (a >= NUM_MST) ? a - NUM_MST : a;
    endfunction

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < NUM_MST; k++) begin
            if (!found && req[wrap(int'(start) + k)]) begin
                found = 1'b1;
                sel   = IDX_W'(wrap(int'(start) + k));
            end
        end
    end

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_MST = 4,
    parameter int IDX_W   = 2,
    parameter int PRIO_W  = 2
) (
    input  logic [NUM_MST-1:0]        req,
    input  logic [NUM_MST*PRIO_W-1:0] prio,
    output logic                      found,
    output logic [IDX_W-1:0]          sel
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            // strict compare keeps the lowest index on a tie
            if (req[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best)) begin
                found = 1'b1;
                sel   = IDX_W'(i);
                best  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/park_arb.sv
module park_arb import arb_pkg::*; #(
    parameter int NUM_MST = 4,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MST-1:0]        req,
    input  logic [NUM_MST-1:0]        xfer_end,
    input  logic                      cfg_policy,
    input  logic [1:0]                cfg_park_mode,
    input  logic [IDX_W-1:0]          cfg_park_id,
    input  logic [NUM_MST*PRIO_W-1:0] cfg_prio,
    output logic [NUM_MST-1:0]        gnt,
    output logic [IDX_W-1:0]          gnt_idx,
    output logic                      gnt_vld
);

    typedef struct packed {
        logic             busy;
        logic             vld;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] last;
        logic             last_vld;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_MST-1:0] own_oh;
    logic [NUM_MST-1:0] cand;
    logic               end_hit;
    logic               rr_found, pr_found, win_found;
    logic [IDX_W-1:0]   rr_sel, pr_sel, win_sel;

    function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] x);
        return (int'(x) == NUM_MST - 1) ? '0 : x + 1'b1;
    endfunction

    // one-hot decode of the current owner
    for (genvar g = 0; g < NUM_MST; g++) begin : g_oh
        assign own_oh[g] = (int'(st_q.owner) == g);
    end

    assign end_hit = st_q.busy && |(xfer_end & own_oh);
    // the finishing master's own request is not a new request
    assign cand    = st_q.busy ? (req & ~own_oh) : req;

    arb_rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_rr (
        .req   (cand),
        .start (st_q.ptr),
        .found (rr_found),
        .sel   (rr_sel)
    );

    arb_prio_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_prio (
        .req   (cand),
        .prio  (cfg_prio),
        .found (pr_found),
        .sel   (pr_sel)
    );

    always_comb begin
        win_found = (pol_e'(cfg_policy) == POL_PRIO) ? pr_found : rr_found;
        win_sel   = (pol_e'(cfg_policy) == POL_PRIO) ? pr_sel   : rr_sel;
    end

    always_comb begin
        logic do_park;
        st_d    = st_q;
        do_park = 1'b0;
        if (st_q.busy) begin
            if (end_hit) begin
                st_d.last     = st_q.owner;
                st_d.last_vld = 1'b1;
                if (win_found) begin
                    st_d.owner = win_sel;
                    st_d.vld   = 1'b1;
                    st_d.ptr   = after(win_sel);
                end else begin
                    st_d.busy = 1'b0;
                    do_park   = 1'b1;
                end
            end
        end else if (st_q.vld && |(req & own_oh)) begin
            // parked master starts with no arbitration cycle
            st_d.busy = 1'b1;
            st_d.ptr  = after(st_q.owner);
        end else if (win_found) begin
            st_d.busy  = 1'b1;
            st_d.vld   = 1'b1;
            st_d.owner = win_sel;
            st_d.ptr   = after(win_sel);
        end else begin
            do_park = 1'b1;
        end

        if (do_park) begin
            unique case (park_e'(cfg_park_mode))
                PARK_LAST: begin
                    st_d.vld   = st_d.last_vld;
                    st_d.owner = st_d.last_vld ? st_d.last : '0;
                end
                PARK_FIXED: begin
                    st_d.vld   = (int'(cfg_park_id) < NUM_MST);
                    st_d.owner = (int'(cfg_park_id) < NUM_MST) ? cfg_park_id : '0;
                end
                default: begin
                    st_d.vld   = 1'b0;
                    st_d.owner = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        gnt     = st_q.vld ? own_oh : '0;
        gnt_idx = st_q.vld ? st_q.owner : '0;
        gnt_vld = st_q.vld;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_vld == (gnt != '0))); // R2

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !end_hit |=> gnt == $past(gnt)); // R5

    AST_FIRST_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy && (req != '0) && ((req & gnt) == '0) |=> (gnt & $past(req)) != '0); // R3

    AST_PARK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy && ((req & gnt) != '0) |=> $stable(gnt)); // R4

    AST_NO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        end_hit && (cand == '0) && (cfg_park_mode == 2'd0) |=> !gnt_vld); // R8

    AST_PARK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        end_hit && (cand == '0) && (cfg_park_mode == 2'd1)
        |=> gnt_vld && gnt_idx == $past(gnt_idx)); // R9

endmodule

// File: tb/sim_park_arb.sv
module sim_park_arb;

    localparam int N  = 4;
    localparam int PW = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req, xfer_end;
    logic          cfg_policy;
    logic [1:0]    cfg_park_mode;
    logic [IW-1:0] cfg_park_id;
    logic [N*PW-1:0] cfg_prio;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;
    logic          gnt_vld;

    always #5 clk = ~clk;

    park_arb u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_end(xfer_end),
        .cfg_policy(cfg_policy), .cfg_park_mode(cfg_park_mode),
        .cfg_park_id(cfg_park_id), .cfg_prio(cfg_prio),
        .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld)
    );

    typedef struct {
        int          cyc;
        logic [N-1:0] g;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int idx_of(input logic [N-1:0] g);
        int r = 0;
        for (int i = 0; i < N; i++) if (g[i]) r = i;
        return r;
    endfunction

    // expectation for the current cycle (before the next edge)
    task automatic now(input logic [N-1:0] g, input string tag);
        item_t it;
        it.cyc = cyc; it.g = g; it.tag = tag;
        sb.push_back(it);
    endtask

    // drive inputs, expect outputs after the coming edge
    task automatic go(input logic [N-1:0] r, input logic [N-1:0] e,
                      input logic [N-1:0] g, input string tag);
        item_t it;
        req = r; xfer_end = e;
        it.cyc = cyc + 1; it.g = g; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // monitor: compares away from the clock edge
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            logic  ev;
            int    ei;
            it = sb.pop_front();
            ev = (it.g != '0);
            ei = idx_of(it.g);
            checks++;
            if (it.cyc != cyc || gnt !== it.g || gnt_vld !== ev || int'(gnt_idx) != ei) begin
                errors++;
                $display("FAIL %s gnt=%b idx=%0d vld=%b expected gnt=%b idx=%0d vld=%b",
                         it.tag, gnt, gnt_idx, gnt_vld, it.g, ei, ev);
            end
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; xfer_end = '0;
        cfg_policy = 1'b0; cfg_park_mode = 2'd0; cfg_park_id = '0; cfg_prio = '0;
        repeat (3) @(negedge clk);
        now(4'b0000, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        go(4'b0000, 4'b0000, 4'b0000, "R1 after reset");
        // first access latency, then hold against stray inputs
        now(4'b0000, "R3 no same-cycle grant");
        go(4'b0100, 4'b0000, 4'b0100, "R3 grant one cycle later");
        go(4'b0110, 4'b0010, 4'b0100, "R5 hold against other req and end");
        go(4'b0110, 4'b0100, 4'b0010, "R11 hand-over excludes finisher");
        cfg_park_mode = 2'd1;
        go(4'b0010, 4'b0010, 4'b0010, "R9 park on last master");
        now(4'b0010, "R4 parked master sees grant at once");
        go(4'b0010, 4'b0000, 4'b0010, "R4 grant unchanged");
        go(4'b0010, 4'b0010, 4'b0010, "R9 repark on last");
        go(4'b1000, 4'b0000, 4'b1000, "R3 non-parked master");
        cfg_park_mode = 2'd2; cfg_park_id = 2'd0;
        go(4'b1000, 4'b1000, 4'b0001, "R10 park on fixed id");
        now(4'b0001, "R4 fixed parked master");
        go(4'b0001, 4'b0000, 4'b0001, "R4 fixed parked hold");
        cfg_park_mode = 2'd0;
        go(4'b0001, 4'b0001, 4'b0000, "R8 no default master");
        // round-robin rotation, pointer at 1
        go(4'b1101, 4'b0000, 4'b0100, "R6 search from pointer");
        go(4'b1101, 4'b0100, 4'b1000, "R6 next after winner");
        go(4'b1001, 4'b1000, 4'b0001, "R6 wrap to zero");
        go(4'b0001, 4'b0001, 4'b0000, "R8 empty after rotation");
        // fixed priority: m0=1 m1=3 m2=3 m3=0
        cfg_policy = 1'b1; cfg_prio = 8'b00_11_11_01;
        go(4'b1111, 4'b0000, 4'b0010, "R7 tie picks lowest index");
        go(4'b1111, 4'b0010, 4'b0100, "R7 next highest value");
        go(4'b1101, 4'b0100, 4'b0001, "R7 value beats index");
        go(4'b0001, 4'b0001, 4'b0000, "R7 done");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            if (sb.size() != 0) begin
                errors++;
                $display("FAIL scoreboard left %0d items expected 0", sb.size());
            end
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule